// File: doc/BRIEF.md
# Motor Driver Supervisor and Standby Sequencer

This block decides when a two-bridge motor driver may switch its power stage and when its gate-drive charge pump may run. It receives a standby-release pin and digital flags from the analog sensors: a thermal trip, a thermal cool-down indication, an overcurrent trip, and two supply-good flags. From these it drives an output enable, a pump run request, a thermal protect indication and a ready flag.

All inputs are first passed through a multi-stage synchronizer. A supply loss forces the block into its reset state. After power is good, the block needs a fresh low-to-high transition on the standby pin before it starts the pump. It then waits a programmable number of clocks for the pump to settle, and only then enables the outputs.

A fault latches the block off. An overcurrent trip is cleared by taking standby low and then high again. A thermal trip is cleared only if standby is seen low while the cool-down flag holds and the trip flag has gone away; a new high level then restarts the pump.

Top module: `pss_supervisor`

## Requirements
- R1: When either supply-good flag is low, `out_en`, `pump_run` and `ready` are 0. Once both supplies are good again, `pump_run` stays 0 until `stby_in` has been seen low and then high.
- R2: With `stby_in` low, `pump_run` and `out_en` are 0 within SYNC_STAGES+2 clocks, and a settle that is in progress is aborted.
- R3: A rising `stby_in` from the idle state starts `pump_run`. `ready` rises after `pump_run` has been high for exactly `settle_cycles` clocks, and a value of 0 counts as 1.
- R4: A thermal trip turns off `out_en` and `pump_run` and holds `prot_flag` at 1 while the block stays latched.
- R5: A thermal latch is released only when `stby_in` is low while `therm_clear_in` is 1 and `therm_trip_in` is 0. A following high on `stby_in` restarts the settle sequence.
- R6: A standby low/high toggle while `therm_clear_in` is 0 leaves the thermal latch in place: `prot_flag` stays 1 and `pump_run` stays 0.
- R7: An overcurrent trip turns off `out_en` and `pump_run` without raising `prot_flag`. The latch holds after the trip flag drops and releases only on a low and then a high of `stby_in`.
- R8: Any asserted fault flag (thermal trip, overcurrent, or a supply-good flag at 0) forces `out_en` to 0 no later than SYNC_STAGES clocks after it is applied.
- R9: When thermal and overcurrent trips arrive together, the thermal latch wins: `prot_flag` is 1 and the cool-down rule of R5 applies.
- R10: `out_en` is 1 only while `pump_run` and `ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| settle_cycles | input | CNT_W | Pump settle time in clocks (0 treated as 1) |
| stby_in | input | 1 | Standby release pin, high = operate |
| therm_trip_in | input | 1 | Junction over-temperature flag |
| therm_clear_in | input | 1 | Temperature back below the hysteresis point |
| ocp_trip_in | input | 1 | Output overcurrent flag |
| vdd_ok_in | input | 1 | Logic supply above its return threshold |
| vm_ok_in | input | 1 | Motor supply above its return threshold |
| out_en | output | 1 | Power stage may switch |
| pump_run | output | 1 | Charge pump enabled |
| prot_flag | output | 1 | Thermal protection latched |
| ready | output | 1 | Pump settled and operating |

## Verification
The assertions check on every cycle that the enable implies a running pump and no synchronized fault, that the protect indication excludes any pump activity, and that a supply loss lands in reset on the next clock. They also check that both trip latches hold unless their own release condition is met, and that the run state is entered only after the settle timer reports done. Only the bench scenarios can show the cycle count of the settle window for a given programmed value, the full restart sequences after each kind of fault, and the need for a fresh standby edge after power returns. The same holds for the rejection of a toggle made while the cool-down flag is false.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [2:0] {
    ST_POR     = 3'd0,
    ST_ARM     = 3'd1,
    ST_IDLE    = 3'd2,
    ST_SETTLE  = 3'd3,
    ST_RUN     = 3'd4,
    ST_TRIP_TH = 3'd5,
    ST_TRIP_OC = 3'd6
  } pss_state_e;

  // positions of the raw flags inside the synchronizer vector
  localparam int unsigned FLG_STBY  = 0;
  localparam int unsigned FLG_TTRIP = 1;
  localparam int unsigned FLG_TCLR  = 2;
  localparam int unsigned FLG_OCP   = 3;
  localparam int unsigned FLG_VDD   = 4;
  localparam int unsigned FLG_VM    = 5;
  localparam int unsigned NUM_FLAGS = 6;

  // last counter value of the settle window; a zero request counts as one clock
  function automatic logic [31:0] settle_last(input logic [31:0] req);
    return (req == 32'd0) ? 32'd0 : req - 32'd1;
  endfunction

  function automatic logic state_pumps(input pss_state_e s);
    return (s == ST_SETTLE) || (s == ST_RUN);
  endfunction

endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= '0;
          else        pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pss_settle_timer.sv
module pss_settle_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  import pss_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = CNT_W'(settle_last(32'(limit)));
  assign done = run && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (!done)      cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R3
  AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done && $past(run)) |-> (cnt_q != '0)); // R3
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stby_s,
  input  logic                therm_trip_s,
  input  logic                therm_clear_s,
  input  logic                ocp_s,
  input  logic                pwr_good_s,
  input  logic                settle_done,
  output pss_pkg::pss_state_e state_q,
  output logic                settle_run,
  output logic                out_en,
  output logic                pump_run,
  output logic                prot_flag,
  output logic                ready
);
  import pss_pkg::*;

  pss_state_e state_d;
  logic       fault_any;
  logic       th_release;

  assign fault_any  = therm_trip_s || ocp_s || !pwr_good_s;
  assign th_release = !stby_s && therm_clear_s && !therm_trip_s;

  always_comb begin
    state_d = state_q;
    if (!pwr_good_s) begin
      state_d = ST_POR;
    end else if (therm_trip_s && state_q != ST_POR) begin
      state_d = ST_TRIP_TH;
    end else if (ocp_s && state_pumps(state_q)) begin
      state_d = ST_TRIP_OC;
    end else begin
      unique case (state_q)
        ST_POR:     state_d = ST_ARM;
        ST_ARM:     if (!stby_s) state_d = ST_IDLE;
        ST_IDLE:    if (stby_s)  state_d = ST_SETTLE;
        ST_SETTLE:  if (!stby_s) state_d = ST_IDLE;
                    else if (settle_done) state_d = ST_RUN;
        ST_RUN:     if (!stby_s) state_d = ST_IDLE;
        ST_TRIP_TH: if (th_release) state_d = ST_IDLE;
        ST_TRIP_OC: if (!stby_s) state_d = ST_IDLE;
        default:    state_d = ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_POR;
    else        state_q <= state_d;
  end

  assign settle_run = (state_q == ST_SETTLE);
  assign pump_run   = state_pumps(state_q);
  assign ready      = (state_q == ST_RUN);
  assign prot_flag  = (state_q == ST_TRIP_TH);
  assign out_en     = (state_q == ST_RUN) && !fault_any;

  AST_UV_TO_POR: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good_s |=> (state_q == ST_POR)); // R1
  AST_STBY_LOW_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_s && pump_run) |=> !pump_run); // R2
  AST_RUN_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(settle_done)); // R3
  AST_PROT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    prot_flag |-> (!pump_run && !out_en)); // R4
  AST_TH_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRIP_TH && pwr_good_s && !(!stby_s && therm_clear_s))
      |=> (state_q == ST_TRIP_TH)); // R6
  AST_OC_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRIP_OC && pwr_good_s && stby_s && !therm_trip_s)
      |=> (state_q == ST_TRIP_OC)); // R7
  AST_FAULT_MASKS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_trip_s || ocp_s || !pwr_good_s) |-> !out_en); // R8
  AST_EN_NEEDS_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (pump_run && ready)); // R10
endmodule

// File: rtl/pss_supervisor.sv
module pss_supervisor #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic             stby_in,
  input  logic             therm_trip_in,
  input  logic             therm_clear_in,
  input  logic             ocp_trip_in,
  input  logic             vdd_ok_in,
  input  logic             vm_ok_in,
  output logic             out_en,
  output logic             pump_run,
  output logic             prot_flag,
  output logic             ready
);
  import pss_pkg::*;

  logic [NUM_FLAGS-1:0] raw_flags;
  logic [NUM_FLAGS-1:0] sync_flags;
  logic                 pwr_good_s;
  logic                 settle_run;
  logic                 settle_done;
  pss_state_e           state_q;

  always_comb begin
    raw_flags            = '0;
    raw_flags[FLG_STBY]  = stby_in;
    raw_flags[FLG_TTRIP] = therm_trip_in;
    raw_flags[FLG_TCLR]  = therm_clear_in;
    raw_flags[FLG_OCP]   = ocp_trip_in;
    raw_flags[FLG_VDD]   = vdd_ok_in;
    raw_flags[FLG_VM]    = vm_ok_in;
  end

  pss_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_flags),
    .q     (sync_flags)
  );

  assign pwr_good_s = sync_flags[FLG_VDD] && sync_flags[FLG_VM];

  pss_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (settle_run),
    .limit (settle_cycles),
    .done  (settle_done)
  );

  pss_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .stby_s        (sync_flags[FLG_STBY]),
    .therm_trip_s  (sync_flags[FLG_TTRIP]),
    .therm_clear_s (sync_flags[FLG_TCLR]),
    .ocp_s         (sync_flags[FLG_OCP]),
    .pwr_good_s    (pwr_good_s),
    .settle_done   (settle_done),
    .state_q       (state_q),
    .settle_run    (settle_run),
    .out_en        (out_en),
    .pump_run      (pump_run),
    .prot_flag     (prot_flag),
    .ready         (ready)
  );

  AST_NO_PUMP_IN_POR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POR) |-> (!pump_run && !out_en && !ready)); // R1
endmodule

// File: tb/pss_supervisor_tb_top.sv
`timescale 1ns/1ps
module pss_supervisor_tb_top;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned CNT_W       = 16;
  localparam real         CLK_PER     = 4.0;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] settle_cycles = 16'd10;
  logic             stby_in = 1'b1;
  logic             therm_trip_in = 1'b0;
  logic             therm_clear_in = 1'b1;
  logic             ocp_trip_in = 1'b0;
  logic             vdd_ok_in = 1'b1;
  logic             vm_ok_in = 1'b1;
  logic             out_en, pump_run, prot_flag, ready;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #(CLK_PER/2.0) clk = ~clk;

  pss_supervisor #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles),
    .stby_in(stby_in), .therm_trip_in(therm_trip_in),
    .therm_clear_in(therm_clear_in), .ocp_trip_in(ocp_trip_in),
    .vdd_ok_in(vdd_ok_in), .vm_ok_in(vm_ok_in),
    .out_en(out_en), .pump_run(pump_run), .prot_flag(prot_flag), .ready(ready));

  function automatic int exp_settle(input int req);
    if (req <= 0) return 1;
    return req;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // raise standby and count clocks of pump without ready
  task automatic start_and_measure(output int n);
    n = 0;
    @(negedge clk);
    stby_in = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (ready) break;
      if (pump_run) n++;
    end
  endtask

  task automatic toggle_restart(input string req, input int setting);
    int n;
    stby_in = 1'b0;
    cyc(6);
    settle_cycles = CNT_W'(setting);
    start_and_measure(n);
    chk(req, n, exp_settle(setting));
    chk(req, out_en, 1);
  endtask

  initial begin
    #(CLK_PER * 150000.0);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    cyc(3);
    rst_n = 1'b1;
    // reset state and R1 fresh release: standby already high at power-up
    chk("R1 reset out_en", out_en, 0);
    cyc(12);
    chk("R1 no pump without fresh edge", pump_run, 0);
    chk("R1 ready low", ready, 0);

    // R3 normal start with 10 clocks
    toggle_restart("R3 settle 10", 10);
    chk("R10 pump with enable", pump_run, 1);

    // R2 standby low stops everything
    stby_in = 1'b0;
    cyc(SYNC_STAGES + 2);
    chk("R2 pump off", pump_run, 0);
    chk("R2 out_en off", out_en, 0);

    // R3 zero and one settle
    toggle_restart("R3 settle 0", 0);
    toggle_restart("R3 settle 1", 1);
    toggle_restart("R3 settle 37", 37);

    // R2 abort during settle
    stby_in = 1'b0;
    cyc(6);
    settle_cycles = 16'd60;
    stby_in = 1'b1;
    cyc(15);
    chk("R2 settling", pump_run, 1);
    stby_in = 1'b0;
    cyc(SYNC_STAGES + 2);
    chk("R2 abort settle", pump_run, 0);
    toggle_restart("R3 after abort", 5);

    // R8 and R7 overcurrent
    ocp_trip_in = 1'b1;
    cyc(SYNC_STAGES);
    chk("R8 ocp masks out_en", out_en, 0);
    cyc(4);
    chk("R7 pump off", pump_run, 0);
    chk("R7 no prot", prot_flag, 0);
    ocp_trip_in = 1'b0;
    cyc(20);
    chk("R7 still latched", pump_run, 0);
    toggle_restart("R7 restart", 8);

    // R4 R6 R5 thermal
    therm_clear_in = 1'b0;
    therm_trip_in = 1'b1;
    cyc(SYNC_STAGES);
    chk("R8 thermal masks out_en", out_en, 0);
    cyc(4);
    chk("R4 prot", prot_flag, 1);
    chk("R4 pump off", pump_run, 0);
    therm_trip_in = 1'b0;
    cyc(6);
    stby_in = 1'b0;
    cyc(8);
    stby_in = 1'b1;
    cyc(30);
    chk("R6 ignored toggle prot", prot_flag, 1);
    chk("R6 ignored toggle pump", pump_run, 0);
    therm_clear_in = 1'b1;
    cyc(20);
    chk("R5 clear alone not enough", prot_flag, 1);
    toggle_restart("R5 thermal restart", 12);
    chk("R5 prot cleared", prot_flag, 0);

    // R9 both trips together
    therm_clear_in = 1'b0;
    therm_trip_in = 1'b1;
    ocp_trip_in = 1'b1;
    cyc(8);
    chk("R9 thermal wins", prot_flag, 1);
    therm_trip_in = 1'b0;
    ocp_trip_in = 1'b0;
    stby_in = 1'b0;
    cyc(8);
    stby_in = 1'b1;
    cyc(20);
    chk("R9 cool-down still needed", prot_flag, 1);
    therm_clear_in = 1'b1;
    toggle_restart("R9 restart", 4);

    // R8 R1 undervoltage during run
    vm_ok_in = 1'b0;
    cyc(SYNC_STAGES);
    chk("R8 uv masks out_en", out_en, 0);
    cyc(4);
    chk("R1 uv pump off", pump_run, 0);
    chk("R1 uv ready off", ready, 0);
    vm_ok_in = 1'b1;
    cyc(30);
    chk("R1 needs new release", pump_run, 0);
    toggle_restart("R1 restart after uv", 6);
    vdd_ok_in = 1'b0;
    cyc(SYNC_STAGES + 3);
    chk("R1 vdd loss", pump_run, 0);
    vdd_ok_in = 1'b1;
    toggle_restart("R1 restart after vdd", 3);

    // random phase: invariants under noisy flags
    settle_cycles = 16'd4;
    for (int it = 0; it < 3000; it++) begin
      @(negedge clk);
      stby_in        = ($urandom % 16) != 0;
      ocp_trip_in    = ($urandom % 64) == 0;
      therm_trip_in  = ($urandom % 128) == 0;
      therm_clear_in = ($urandom % 4) != 0;
      vdd_ok_in      = ($urandom % 200) != 0;
      vm_ok_in       = ($urandom % 200) != 0;
      #1;
      chk("R10 enable implies pump and ready", int'(out_en && !(pump_run && ready)), 0);
      chk("R4 protect excludes pump", int'(prot_flag && pump_run), 0);
    end

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule